// File: doc/BRIEF.md
# Configuration Address-Data Port Bridge

The bridge gives a host an indirect window into the configuration space of devices on a downstream bus. The host first writes a 32-bit address register that names a target bus, device, function and dword-aligned register, and holds an enable flag. It then issues 1-, 2- or 4-byte accesses to a data window. When the flag is set and the access is well formed, each data-window access becomes exactly one configuration read or write request on a simple downstream request/acknowledge interface. The lane byte enables and the write data placement follow from the access size and from the byte offset inside the window.

Read responses are moved back from their lanes to the low end of the host data bus and zero-extended to the access size. A target that does not claim the cycle reads as all ones, so probing an empty slot returns 0xFFFF for the 16-bit identification field. While one downstream cycle is outstanding the bridge shows itself not ready, and it ignores any host request made in that time.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register reads zero (enable flag clear), no downstream request is active, host_ready is high and host_done is low.
- R2: A host write with host_sel=0 stores host_wdata into the address register with bits 1:0 forced to zero. A host read with host_sel=0 returns the register. Neither starts a downstream cycle, and host_done pulses in the cycle after the request.
- R3: During a downstream cycle dn_bus, dn_dev and dn_fn carry address register bits 23:16, 15:11 and 10:8. dn_reg carries bits 7:2 with its two low bits zero. All of them, and dn_be, stay stable until dn_ack.
- R4: With address bit 31 clear, a well-formed data access (host_sel=1) starts no downstream cycle. It completes in the next cycle with host_err low. A read returns all ones masked to the access size, and a write is dropped.
- R5: Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. dn_be is 4'b0001 shifted left by host_off for 1 byte, 4'b0011 shifted by host_off for 2 bytes, and 4'b1111 for 4 bytes. On the enabled lanes, dn_wdata is host_wdata shifted left by 8*host_off.
- R6: A read returns the acknowledged dn_rdata shifted right by 8*host_off, masked to the low 8, 16 or 32 bits for the access size.
- R7: An access with size code 3, a 2-byte access at offset 3, or a 4-byte access at a nonzero offset is rejected whether or not the enable flag is set. It starts no cycle, and completes in the next cycle with host_err high and host_rdata all ones.
- R8: host_ready is low from the accept of an issued cycle until its completion. A host request made while host_ready is low has no effect: it starts no cycle and does not change the address register.
- R9: When the acknowledge comes with dn_present low, the read returns all ones masked to the access size, so a 2-byte read at offset 0 returns 0x0000FFFF.
- R10: dn_req stays high until dn_ack. host_done pulses exactly once per accepted request, in the cycle after dn_ack for an issued cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, taken when host_ready is high |
| host_sel | input | 1 | 0 selects the address register, 1 the data window |
| host_we | input | 1 | 1 for write, 0 for read |
| host_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| host_off | input | 2 | Byte offset inside the data window |
| host_wdata | input | 32 | Host write data, low-aligned |
| host_ready | output | 1 | Bridge can take a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Completion was a rejected access |
| host_rdata | output | 32 | Read data, valid with host_done |
| dn_req | output | 1 | Downstream configuration request, held until dn_ack |
| dn_we | output | 1 | Downstream write when high |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_fn | output | 3 | Target function number |
| dn_reg | output | 8 | Target dword-aligned register offset |
| dn_be | output | 4 | Lane byte enables |
| dn_wdata | output | 32 | Lane-placed write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |
| dn_present | input | 1 | Target claimed the cycle |

## Verification
The hardest situation to reach is a host request that arrives while a downstream cycle is still outstanding, because a well-behaved requester waits for host_ready. The bench holds the downstream acknowledge back for several cycles with a directed sequence, issues an address register write during that stall, and then reads the register back to show it kept its value. Random traffic with varied acknowledge delays, every size and offset pairing, targets that do not respond and a cleared enable flag covers the remaining lane and rejection paths.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned FN_W   = 3;
  localparam int unsigned REG_W  = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Access would cross the dword or uses a reserved size code.
  function automatic logic size_bad(input logic [1:0] sz, input logic [OFF_W-1:0] off);
    case (acc_size_e'(sz))
      SZ_BYTE: size_bad = 1'b0;
      SZ_HALF: size_bad = (off == OFF_W'(3));
      SZ_WORD: size_bad = (off != '0);
      default: size_bad = 1'b1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_be(input logic [1:0] sz, input logic [OFF_W-1:0] off);
    case (acc_size_e'(sz))
      SZ_BYTE: lane_be = LANES'(4'b0001) << off;
      SZ_HALF: lane_be = LANES'(4'b0011) << off;
      default: lane_be = '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: size_mask = DATA_W'(32'h0000_00FF);
      SZ_HALF: size_mask = DATA_W'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= {wdata[DATA_W-1:2], 2'b00};
  end
endmodule

// File: rtl/cfg_wr_steer.sv
module cfg_wr_steer
  import cfg_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_wdata
);
  always_comb begin
    be         = lane_be(size, off);
    lane_wdata = wdata << {off, 3'b000};
  end
endmodule

// File: rtl/cfg_rd_steer.sv
module cfg_rd_steer
  import cfg_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic              present,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] host_data
);
  logic [DATA_W-1:0] src;
  always_comb begin
    src       = present ? raw : '1;
    host_data = (src >> {off, 3'b000}) & size_mask(size);
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [1:0]        host_size,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic              host_err,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [BUS_W-1:0]  dn_bus,
  output logic [DEV_W-1:0]  dn_dev,
  output logic [FN_W-1:0]   dn_fn,
  output logic [REG_W-1:0]  dn_reg,
  output logic [LANES-1:0]  dn_be,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ack,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_present
);
  logic [DATA_W-1:0] addr_q;
  logic              busy;
  logic [1:0]        p_size;
  logic [OFF_W-1:0]  p_off;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wd_c;
  logic [DATA_W-1:0] rd_c;

  // Named events used by the logic and by the checker.
  logic acc_fire, acc_addr, acc_data, acc_bad, acc_off, acc_go, dn_fire;
  assign host_ready = ~busy;
  assign acc_fire   = host_req & ~busy;
  assign acc_addr   = acc_fire & ~host_sel;
  assign acc_data   = acc_fire & host_sel;
  assign acc_bad    = acc_data & size_bad(host_size, host_off);
  assign acc_off    = acc_data & ~acc_bad & ~addr_q[DATA_W-1];
  assign acc_go     = acc_data & ~acc_bad & addr_q[DATA_W-1];
  assign dn_fire    = busy & dn_ack;
  assign dn_req     = busy;

  cfg_addr_reg u_areg (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_addr & host_we),
    .wdata(host_wdata), .addr_q(addr_q)
  );

  cfg_wr_steer u_wst (
    .size(host_size), .off(host_off), .wdata(host_wdata),
    .be(be_c), .lane_wdata(wd_c)
  );

  cfg_rd_steer u_rst (
    .size(p_size), .off(p_off), .present(dn_present),
    .raw(dn_rdata), .host_data(rd_c)
  );

  // Cycle tracking and target snapshot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dn_we    <= 1'b0;
      p_size   <= '0;
      p_off    <= '0;
      dn_bus   <= '0;
      dn_dev   <= '0;
      dn_fn    <= '0;
      dn_reg   <= '0;
      dn_be    <= '0;
      dn_wdata <= '0;
    end else if (acc_go) begin
      busy     <= 1'b1;
      dn_we    <= host_we;
      p_size   <= host_size;
      p_off    <= host_off;
      dn_bus   <= addr_q[23:16];
      dn_dev   <= addr_q[15:11];
      dn_fn    <= addr_q[10:8];
      dn_reg   <= {addr_q[7:2], 2'b00};
      dn_be    <= be_c;
      dn_wdata <= wd_c;
    end else if (dn_fire) begin
      busy     <= 1'b0;
    end
  end

  // Completion towards the host.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_done  <= 1'b0;
      host_err   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_done <= acc_addr | acc_bad | acc_off | dn_fire;
      host_err  <= acc_bad;
      if (acc_addr)     host_rdata <= host_we ? '0 : addr_q;
      else if (acc_bad) host_rdata <= '1;
      else if (acc_off) host_rdata <= host_we ? '0 : size_mask(host_size);
      else if (dn_fire) host_rdata <= dn_we ? '0 : rd_c;
    end
  end
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk
  import cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_done,
  input logic              host_err,
  input logic [DATA_W-1:0] host_rdata,
  input logic              dn_req,
  input logic              dn_ack,
  input logic [BUS_W-1:0]  dn_bus,
  input logic [REG_W-1:0]  dn_reg,
  input logic [LANES-1:0]  dn_be,
  input logic              acc_go,
  input logic              dn_fire
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !dn_req && !host_done);

  p_reg_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> dn_reg[1:0] == 2'b00);

  p_target_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> $stable(dn_reg) && $stable(dn_bus) && $stable(dn_be));

  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> dn_be != '0);

  p_err_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_done && host_err |-> host_rdata == '1);

  p_issue_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> dn_req && !host_ready);

  p_stall_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready && !dn_ack |=> !host_done);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req);

  p_ack_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fire |=> host_done && !host_err && host_ready);
endmodule

bind cfg_port_bridge cfg_port_bridge_chk u_chk (.*);

// File: tb/sim_cfg_port_bridge.sv
`timescale 1ns/1ps
module sim_cfg_port_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_sel = 1'b0, host_we = 1'b0;
  logic [1:0]  host_size = '0, host_off = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, host_done, host_err;
  logic [31:0] host_rdata;
  logic        dn_req, dn_we;
  logic [7:0]  dn_bus, dn_reg;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_fn;
  logic [3:0]  dn_be;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0, dn_present = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0, errors = 0, ncyc = 0, resp_dly = 0;
  logic [7:0]  cap_bus, cap_reg;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [3:0]  cap_be;
  logic        cap_we;
  logic [31:0] cap_wdata;

  always #4 clk = ~clk;

  cfg_port_bridge u0 (.*);

  function automatic logic [31:0] model_val(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [7:0] r);
    return {b, d, f, r, 8'hC3} ^ 32'h5A96_0F1E;
  endfunction
  function automatic int nbytes(logic [1:0] sz);
    return 1 << sz;
  endfunction
  function automatic logic exp_bad(logic [1:0] sz, logic [1:0] off);
    return (sz == 2'd3) || (int'(off) + nbytes(sz) > 4);
  endfunction
  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] off);
    return 4'(((1 << nbytes(sz)) - 1) << off);
  endfunction
  function automatic logic [31:0] keep(logic [31:0] v, logic [1:0] sz);
    return (nbytes(sz) == 4) ? v : (v & ((32'd1 << (8 * nbytes(sz))) - 1));
  endfunction
  function automatic logic [31:0] lanes_mask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Downstream target model.
  initial begin
    forever begin
      @(negedge clk);
      if (dn_req && !dn_ack) begin
        cap_bus = dn_bus; cap_dev = dn_dev; cap_fn = dn_fn; cap_reg = dn_reg;
        cap_be = dn_be; cap_we = dn_we; cap_wdata = dn_wdata;
        ncyc++;
        repeat (resp_dly) @(negedge clk);
        dn_present = (dn_dev != 5'd31);
        dn_rdata   = dn_present ? model_val(dn_bus, dn_dev, dn_fn, dn_reg) : $urandom;
        dn_ack     = 1'b1;
        @(negedge clk);
        dn_ack     = 1'b0;
      end
    end
  end

  task automatic acc(input logic sel, input logic we, input logic [1:0] sz, input logic [1:0] off,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er, output int dc);
    int c0 = ncyc;
    int t = 0;
    @(negedge clk);
    host_req = 1'b1; host_sel = sel; host_we = we; host_size = sz; host_off = off; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_done && t < 40) begin @(negedge clk); t++; end
    rd = host_rdata; er = host_err; dc = ncyc - c0;
  endtask

  // Full data-window access with expectations derived from the requirements.
  task automatic data_check(input logic [31:0] areg, input logic we, input logic [1:0] sz,
                            input logic [1:0] off, input logic [31:0] wd);
    logic [31:0] rd, e;
    logic er;
    int dc;
    logic bad = exp_bad(sz, off);
    logic en = areg[31];
    acc(1'b1, we, sz, off, wd, rd, er, dc);
    if (bad) begin
      chk(er == 1'b1 && dc == 0, "R7 reject flag/no cycle", {31'(dc), er}, 32'h1);
      chk(rd == 32'hFFFF_FFFF, "R7 reject data", rd, 32'hFFFF_FFFF);
    end else if (!en) begin
      chk(er == 1'b0 && dc == 0, "R4 disabled no cycle", {31'(dc), er}, 32'h0);
      if (!we) chk(rd == keep(32'hFFFF_FFFF, sz), "R4 disabled read", rd, keep(32'hFFFF_FFFF, sz));
    end else begin
      chk(dc == 1 && er == 1'b0, "R10 one cycle", {31'(dc), er}, 32'h2);
      chk({cap_bus, cap_dev, cap_fn, cap_reg} == {areg[23:8], areg[7:2], 2'b00},
          "R3 target", {8'h0, cap_bus, cap_dev, cap_fn, cap_reg}, {8'h0, areg[23:2], 2'b00});
      chk(cap_be == exp_be(sz, off), "R5 byte enables", {28'h0, cap_be}, {28'h0, exp_be(sz, off)});
      chk(cap_we == we, "R5 direction", {31'h0, cap_we}, {31'h0, we});
      if (we) begin
        e = (wd << (8 * off)) & lanes_mask(exp_be(sz, off));
        chk((cap_wdata & lanes_mask(exp_be(sz, off))) == e, "R5 lane write data",
            cap_wdata & lanes_mask(exp_be(sz, off)), e);
      end else if (areg[15:11] == 5'd31) begin
        chk(rd == keep(32'hFFFF_FFFF, sz), "R9 absent target", rd, keep(32'hFFFF_FFFF, sz));
      end else begin
        e = keep(model_val(areg[23:16], areg[15:11], areg[10:8], {areg[7:2], 2'b00}) >> (8 * off), sz);
        chk(rd == e, "R6 read steering", rd, e);
      end
    end
  endtask

  task automatic set_addr(input logic [31:0] a);
    logic [31:0] rd;
    logic er;
    int dc;
    acc(1'b0, 1'b1, 2'd2, 2'd0, a, rd, er, dc);
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, a;
    logic er;
    int dc, t;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!dn_req && host_ready && !host_done, "R1 idle after reset",
        {29'h0, dn_req, host_ready, host_done}, 32'h2);
    rst_n = 1'b1;
    acc(1'b0, 1'b0, 2'd2, 2'd0, 32'h0, rd, er, dc);
    chk(rd == 32'h0, "R1 address register cleared", rd, 32'h0);

    // R2 write and read back, low bits forced to zero, no cycle
    acc(1'b0, 1'b1, 2'd2, 2'd0, 32'h8012_3A7F, rd, er, dc);
    chk(dc == 0, "R2 address write no cycle", 32'(dc), 32'h0);
    acc(1'b0, 1'b0, 2'd2, 2'd0, 32'h0, rd, er, dc);
    chk(rd == 32'h8012_3A7C && dc == 0, "R2 address readback", rd, 32'h8012_3A7C);

    // Directed lane cases
    a = 32'h8012_3A7C;
    data_check(a, 1'b0, 2'd2, 2'd0, 32'h0);
    data_check(a, 1'b0, 2'd1, 2'd2, 32'h0);
    data_check(a, 1'b0, 2'd0, 2'd3, 32'h0);
    data_check(a, 1'b1, 2'd0, 2'd3, 32'h0000_00AB);
    data_check(a, 1'b1, 2'd1, 2'd1, 32'h0000_BEEF);
    data_check(a, 1'b0, 2'd1, 2'd3, 32'h0);   // R7
    data_check(a, 1'b1, 2'd2, 2'd1, 32'h0);   // R7
    data_check(a, 1'b0, 2'd3, 2'd0, 32'h0);   // R7
    // R9 vendor identification of an absent slot
    a = 32'h8003_F800; set_addr(a);
    data_check(a, 1'b0, 2'd1, 2'd0, 32'h0);
    // R4 enable flag clear
    a = 32'h0012_3A00; set_addr(a);
    data_check(a, 1'b0, 2'd1, 2'd0, 32'h0);
    data_check(a, 1'b1, 2'd2, 2'd0, 32'h1234_5678);

    // R8 request during an outstanding cycle is ignored
    a = 32'h8001_0808; set_addr(a);
    resp_dly = 4;
    dc = ncyc;
    @(negedge clk);
    host_req = 1'b1; host_sel = 1'b1; host_we = 1'b0; host_size = 2'd2; host_off = 2'd0;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    chk(host_ready == 1'b0, "R8 not ready while busy", {31'h0, host_ready}, 32'h0);
    host_req = 1'b1; host_sel = 1'b0; host_we = 1'b1; host_wdata = 32'h8077_7700;
    @(negedge clk);
    host_req = 1'b0;
    t = 0;
    while (!host_done && t < 40) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(host_done == 1'b0, "R10 single completion", {31'h0, host_done}, 32'h0);
    chk(ncyc - dc == 1, "R8 one downstream cycle", 32'(ncyc - dc), 32'h1);
    resp_dly = 0;
    acc(1'b0, 1'b0, 2'd2, 2'd0, 32'h0, rd, er, dc);
    chk(rd == a, "R8 address register untouched", rd, a);

    // Random traffic
    for (int i = 0; i < 300; i++) begin
      a = $urandom;
      a[31] = ($urandom % 8) != 0;
      if ($urandom % 6 == 0) a[15:11] = 5'd31;
      a[1:0] = 2'b00;
      set_addr(a);
      resp_dly = $urandom % 4;
      data_check(a, 1'($urandom), 2'($urandom), 2'($urandom), $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule